// File: doc/BRIEF.md
# Scanline Timer with CPU Sync Halt

This block times one horizontal video line from the colour clock and needs no frame store. It counts colour clocks around a fixed line length. It flags the leading stretch of each line as horizontal blank, and for the rest of the line it gives the index of the visible pixel. It marks the first clock of every line with a one-cycle pulse. Vertical structure is not part of this block: software builds frames by counting these line-start pulses.

The CPU clock is made from the same colour clock. It is a clock enable that is high on one colour clock in three, and its phase is locked to the start of the line. A one-cycle write strobe from the CPU takes away its ready signal until the next line begins. Software uses this to lock its timing to the beam position.

Top module: `scanline_timer`

## Requirements
- R1: `hpos_o` counts colour clocks from 0 to 227 and then wraps to 0, moving up by one on every clock.
- R2: `hblank_o` is 1 exactly while `hpos_o` is below 68.
- R3: `vis_o` equals `hpos_o` minus 68 while `hblank_o` is 0 (range 0 to 159), and is 0 while `hblank_o` is 1.
- R4: `cpu_ce_o` is 1 exactly on the clocks where `hpos_o` is a multiple of 3, so one colour clock in three.
- R5: `line_start_o` is 1 exactly on the clocks where `hpos_o` is 0.
- R6: When `line_wait_i` is 1 at a rising edge, `cpu_rdy_o` is 0 from the next clock, provided `hpos_o` was not 227 at that edge.
- R7: After such a strobe, `cpu_rdy_o` stays 0 until the clock where `hpos_o` is 0. It is 1 on that clock, which is also the first clock-enable of the new line.
- R8: A strobe while `cpu_rdy_o` is already 0 has no effect: ready still returns at `hpos_o` = 0 of the next line.
- R9: A strobe at the edge where `hpos_o` is 227 leaves `cpu_rdy_o` at 1, because the next line starts at that same edge.
- R10: After a synchronous reset, `hpos_o`=0, `hblank_o`=1, `vis_o`=0, `cpu_ce_o`=1, `line_start_o`=1 and `cpu_rdy_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Colour clock |
| rst_i | input | 1 | Synchronous reset, active high |
| line_wait_i | input | 1 | CPU write strobe that requests a halt until the next line |
| hpos_o | output | 8 | Colour clock position within the line |
| hblank_o | output | 1 | Horizontal blank flag |
| vis_o | output | 8 | Visible pixel index, 0 during blank |
| cpu_ce_o | output | 1 | CPU clock enable |
| cpu_rdy_o | output | 1 | CPU ready; 0 while the CPU is halted |
| line_start_o | output | 1 | One-cycle pulse on colour clock 0 |

## Verification
The assertions take the sync strobe to be a level sampled at each rising edge. They also assume reset has been applied once before any check starts, because every property is gated off while reset is high. The bench drives the strobe only on falling edges and holds each pulse for exactly one clock. It places pulses at the start of the line, in the middle of the line, at the last clock of the line, and again while the CPU is already halted. It also runs full lines with no pulse at all.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic {
    RUN_ST  = 1'b0,
    HOLD_ST = 1'b1
  } halt_st_t;

  function automatic int safe_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/scan_hcount.sv
module scan_hcount #(
  parameter int LINE_CLKS   = 228,
  parameter int HBLANK_CLKS = 68,
  parameter int W           = 8
) (
  input  logic         clk_i,
  input  logic         rst_i,
  output logic         wrap_next_o,
  output logic [W-1:0] hpos_q_o,
  output logic         hblank_q_o,
  output logic [W-1:0] vis_q_o,
  output logic         lstart_q_o
);
  localparam logic [W-1:0] LAST = W'(LINE_CLKS - 1);
  localparam logic [W-1:0] HB   = W'(HBLANK_CLKS);

  logic [W-1:0] h_q, h_next;

  always_comb begin
    h_next = (h_q == LAST) ? '0 : h_q + 1'b1;
  end

  assign wrap_next_o = (h_next == '0);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      h_q        <= '0;
      hblank_q_o <= 1'b1;
      vis_q_o    <= '0;
      lstart_q_o <= 1'b1;
    end else begin
      h_q        <= h_next;
      hblank_q_o <= (h_next < HB);
      vis_q_o    <= (h_next < HB) ? '0 : h_next - HB;
      lstart_q_o <= (h_next == '0);
    end
  end

  assign hpos_q_o = h_q;
endmodule

// File: rtl/scan_cpu_div.sv
module scan_cpu_div #(
  parameter int CPU_DIV = 3,
  parameter int PW      = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic wrap_next_i,
  output logic ce_next_o,
  output logic ce_q_o
);
  localparam logic [PW-1:0] PLAST = PW'(CPU_DIV - 1);

  logic [PW-1:0] ph_q, ph_next;

  always_comb begin
    if (wrap_next_i)        ph_next = '0;
    else if (ph_q == PLAST) ph_next = '0;
    else                    ph_next = ph_q + 1'b1;
  end

  assign ce_next_o = (ph_next == '0);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ph_q   <= '0;
      ce_q_o <= 1'b1;
    end else begin
      ph_q   <= ph_next;
      ce_q_o <= ce_next_o;
    end
  end
endmodule

// File: rtl/scan_halt.sv
module scan_halt
  import scan_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic wait_i,
  input  logic wrap_next_i,
  input  logic ce_next_i,
  output logic rdy_q_o
);
  halt_st_t st_q, st_next;

  always_comb begin
    if (wrap_next_i)  st_next = RUN_ST;
    else if (wait_i)  st_next = HOLD_ST;
    else              st_next = st_q;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      st_q    <= RUN_ST;
      rdy_q_o <= 1'b1;
    end else begin
      st_q <= st_next;
      if (st_next == HOLD_ST) rdy_q_o <= 1'b0;
      else if (ce_next_i)     rdy_q_o <= 1'b1;
    end
  end
endmodule

// File: rtl/scanline_timer.sv
module scanline_timer #(
  parameter int LINE_CLKS   = 228,
  parameter int HBLANK_CLKS = 68,
  parameter int CPU_DIV     = 3,
  localparam int W          = scan_pkg::safe_bits(LINE_CLKS),
  localparam int PW         = scan_pkg::safe_bits(CPU_DIV)
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         line_wait_i,
  output logic [W-1:0] hpos_o,
  output logic         hblank_o,
  output logic [W-1:0] vis_o,
  output logic         cpu_ce_o,
  output logic         cpu_rdy_o,
  output logic         line_start_o
);
  logic wrap_next;
  logic ce_next;

  scan_hcount #(
    .LINE_CLKS  (LINE_CLKS),
    .HBLANK_CLKS(HBLANK_CLKS),
    .W          (W)
  ) u_hcount (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .wrap_next_o(wrap_next),
    .hpos_q_o   (hpos_o),
    .hblank_q_o (hblank_o),
    .vis_q_o    (vis_o),
    .lstart_q_o (line_start_o)
  );

  scan_cpu_div #(
    .CPU_DIV(CPU_DIV),
    .PW     (PW)
  ) u_div (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .wrap_next_i(wrap_next),
    .ce_next_o  (ce_next),
    .ce_q_o     (cpu_ce_o)
  );

  scan_halt u_halt (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .wait_i     (line_wait_i),
    .wrap_next_i(wrap_next),
    .ce_next_i  (ce_next),
    .rdy_q_o    (cpu_rdy_o)
  );
endmodule

// File: rtl/scanline_timer_chk.sv
module scanline_timer_chk #(
  parameter int LINE_CLKS   = 228,
  parameter int HBLANK_CLKS = 68,
  parameter int CPU_DIV     = 3,
  parameter int W           = 8
) (
  input logic         clk_i,
  input logic         rst_i,
  input logic         line_wait_i,
  input logic [W-1:0] hpos_o,
  input logic         hblank_o,
  input logic [W-1:0] vis_o,
  input logic         cpu_ce_o,
  input logic         cpu_rdy_o,
  input logic         line_start_o
);
  localparam logic [W-1:0] LAST = W'(LINE_CLKS - 1);
  localparam logic [W-1:0] HB   = W'(HBLANK_CLKS);

  // R1
  hpos_wrap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (hpos_o == LAST) |=> (hpos_o == '0));
  // R1
  hpos_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (hpos_o != LAST) |=> (hpos_o == $past(hpos_o) + 1'b1));
  // R2
  hblank_span_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    hblank_o == (hpos_o < HB));
  // R3
  vis_blank_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    hblank_o |-> (vis_o == '0));
  // R3
  vis_index_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !hblank_o |-> (vis_o == hpos_o - HB));
  // R4
  ce_phase_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    cpu_ce_o == ((32'(hpos_o) % CPU_DIV) == 0));
  // R5
  lstart_pos_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    line_start_o == (hpos_o == '0));
  // R6
  halt_enter_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (line_wait_i && hpos_o != LAST) |=> !cpu_rdy_o);
  // R7
  halt_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!cpu_rdy_o && hpos_o != LAST) |=> !cpu_rdy_o);
  // R7
  halt_release_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    line_start_o |-> (cpu_rdy_o && cpu_ce_o));
endmodule

bind scanline_timer scanline_timer_chk #(
  .LINE_CLKS  (LINE_CLKS),
  .HBLANK_CLKS(HBLANK_CLKS),
  .CPU_DIV    (CPU_DIV),
  .W          (W)
) u_chk (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .line_wait_i (line_wait_i),
  .hpos_o      (hpos_o),
  .hblank_o    (hblank_o),
  .vis_o       (vis_o),
  .cpu_ce_o    (cpu_ce_o),
  .cpu_rdy_o   (cpu_rdy_o),
  .line_start_o(line_start_o)
);

// File: tb/sim_scanline_timer.sv
module sim_scanline_timer;
  localparam int PERIOD = 10;
  localparam int LINE   = 228;
  localparam int HB     = 68;
  localparam int DIV    = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       line_wait = 1'b0;
  logic [7:0] hpos, vis;
  logic       hblank, ce, rdy, lstart;

  int errors = 0;
  int checks = 0;
  int exp_h  = 0;
  bit exp_rdy = 1'b1;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  scanline_timer u0 (
    .clk_i       (clk),
    .rst_i       (rst),
    .line_wait_i (line_wait),
    .hpos_o      (hpos),
    .hblank_o    (hblank),
    .vis_o       (vis),
    .cpu_ce_o    (ce),
    .cpu_rdy_o   (rdy),
    .line_start_o(lstart)
  );

  task automatic chk(input int act, input int exp, input string req, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s at line pos %0d: actual=%0d expected=%0d", req, what, exp_h, act, exp);
    end
  endtask

  task automatic check_all(input string rdy_req);
    chk(int'(hpos), exp_h, "R1", "hpos");
    chk(int'(hblank), int'(exp_h < HB), "R2", "hblank");
    chk(int'(vis), (exp_h < HB) ? 0 : exp_h - HB, "R3", "vis");
    chk(int'(ce), int'((exp_h % DIV) == 0), "R4", "cpu_ce");
    chk(int'(lstart), int'(exp_h == 0), "R5", "line_start");
    chk(int'(rdy), int'(exp_rdy), rdy_req, "cpu_rdy");
  endtask

  // one clock: check at the falling edge, drive, then advance the model at the rising edge
  task automatic cyc(input bit strobe, input string rdy_req);
    check_all(rdy_req);
    line_wait = strobe;
    @(posedge clk);
    if (strobe && exp_h != LINE - 1) exp_rdy = 1'b0;
    exp_h = (exp_h == LINE - 1) ? 0 : exp_h + 1;
    if (exp_h == 0) exp_rdy = 1'b1;
    @(negedge clk);
    line_wait = 1'b0;
  endtask

  task automatic goto(input int pos, input string rdy_req);
    while (exp_h != pos) cyc(1'b0, rdy_req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    chk(int'(hpos), 0, "R10", "hpos");
    chk(int'(hblank), 1, "R10", "hblank");
    chk(int'(vis), 0, "R10", "vis");
    chk(int'(ce), 1, "R10", "cpu_ce");
    chk(int'(lstart), 1, "R10", "line_start");
    chk(int'(rdy), 1, "R10", "cpu_rdy");
    rst = 1'b0;

    // R1..R5: full sweep of two lines with no strobe
    for (int i = 0; i < 2 * LINE; i++) cyc(1'b0, "R7");

    // R6: strobe early in the line, R7: held until the next line
    goto(10, "R7");
    cyc(1'b1, "R6");
    goto(0, "R7");
    cyc(1'b0, "R7");

    // R8: second strobe while already halted
    goto(100, "R7");
    cyc(1'b1, "R6");
    goto(150, "R8");
    cyc(1'b1, "R8");
    goto(0, "R8");
    for (int i = 0; i < 6; i++) cyc(1'b0, "R8");

    // R9: strobe on the last clock of a line
    goto(LINE - 1, "R7");
    cyc(1'b1, "R9");
    for (int i = 0; i < 12; i++) cyc(1'b0, "R9");

    // R6: strobe on the first clock of a line
    goto(0, "R7");
    cyc(1'b1, "R6");
    goto(0, "R7");

    // strobes spread over the visible part
    for (int p = HB; p < LINE - 1; p += 37) begin
      goto(p, "R7");
      cyc(1'b1, "R6");
    end
    goto(0, "R7");
    cyc(1'b0, "R7");

    // R10: reset in mid line while halted
    goto(40, "R7");
    cyc(1'b1, "R6");
    cyc(1'b0, "R7");
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    exp_h = 0;
    exp_rdy = 1'b1;
    chk(int'(hpos), 0, "R10", "hpos after mid-line reset");
    chk(int'(rdy), 1, "R10", "cpu_rdy after mid-line reset");
    rst = 1'b0;
    for (int i = 0; i < LINE; i++) cyc(1'b0, "R7");

    finish_run();
  end
endmodule